// File: doc/BRIEF.md
# FIFO Threshold Interrupt Status Unit

This block holds the transmit and receive byte queues of a serial bus controller and derives the raw interrupt status bits from their fill levels and from events reported by the bus engine. The processor pushes commands into the transmit queue and pops received bytes from the receive queue. The bus engine drains the transmit queue and fills the receive queue. Both queues are `DEPTH` entries deep.

Two status bits follow the queue levels against programmable thresholds. Five more are sticky event flags: transmit overflow, receive overflow, receive underflow, slave read request and transmit abort. The read-request flag also drives a request to stretch the bus clock low. Clearing the enable input flushes both queues. The overflow and underflow flags survive a disable until the bus engine reports that it is idle.

The status vector bit positions are fixed: 0 tx-low, 1 rx-high, 2 tx-overflow, 3 rx-overflow, 4 rx-underflow, 5 read-request, 6 abort. Clear strobe bits map as follows: 0 tx-overflow, 1 rx-overflow, 2 rx-underflow, 3 read-request, 4 abort.

Top module: `fifo_irq_status`

## Requirements
- R1: Each queue returns bytes in write order, and its head byte is presented continuously. The level output counts stored entries, ranges from 0 to DEPTH, and updates the cycle after a push or pop.
- R2: While enabled, status bit 1 is 1 exactly when the receive level is at least the receive threshold plus one. A threshold of 0 therefore fires at one entry. The bit clears by itself when the level falls below that point.
- R3: A receive or transmit threshold above DEPTH-1 behaves as DEPTH-1. With threshold 200 and DEPTH 16, for example, status bit 1 rises only when the 16th entry is stored.
- R4: While enabled, status bit 0 is 1 exactly when the transmit level is at or below the transmit threshold.
- R5: While enable is 0, both levels are 0 from the next cycle on and status bit 1 is 0. Status bit 0 equals the engine-busy input.
- R6: A processor write while the transmit queue holds DEPTH entries sets status bit 2 on the next cycle. The byte is dropped, and the level and head byte are unchanged.
- R7: A received byte while the receive queue holds DEPTH entries sets status bit 3. The byte is discarded.
- R8: A processor read while the receive queue is empty sets status bit 4. The read data output is 0 whenever the receive queue is empty.
- R9: Status bits 2 to 4 keep their value while disabled and busy. They clear on the first cycle in which enable and engine-busy are both 0.
- R10: A slave-read-addressed strobe sets status bit 5. The clock-hold output follows bit 5 until clear strobe bit 3 clears it.
- R11: An abort strobe sets status bit 6. It stays set until clear strobe bit 4 is applied.
- R12: A clear strobe bit clears its sticky flag on the next cycle. When a set event and the clear arrive in the same cycle, the flag stays 1.
- R13: While enable is 0, processor writes and reads, received bytes, slave-read strobes and abort strobes change no level and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; 0 flushes both queues |
| engine_busy | input | 1 | Master or slave state machine still active |
| cpu_wr | input | 1 | Processor write of a command byte |
| cpu_wdata | input | DW | Command byte |
| cpu_rd | input | 1 | Processor read of a received byte |
| cpu_rdata | output | DW | Receive queue head, 0 when empty |
| tx_pop | input | 1 | Bus engine consumes the transmit head |
| tx_dout | output | DW | Transmit queue head, 0 when empty |
| rx_vld | input | 1 | Bus engine delivers a received byte |
| rx_data | input | DW | Received byte |
| slv_rd_addr | input | 1 | Addressed as slave for a read |
| abort_evt | input | 1 | Transmit abort event |
| rx_thr | input | TW | Receive threshold (fires at value+1 entries) |
| tx_thr | input | TW | Transmit threshold |
| clr_mask | input | 5 | Clear strobes for the sticky flags |
| tx_level | output | LW | Transmit queue level |
| rx_level | output | LW | Receive queue level |
| raw_status | output | 7 | Raw status vector |
| hold_scl | output | 1 | Request to hold the bus clock low |

## Verification
The hardest state to reach is a disable that arrives while the engine is still busy and overflow and underflow flags are already set. Queue-flush behaviour and sticky-flag retention then overlap with strobes that must be ignored. The stimulus first overfills the transmit queue and underreads the receive queue. It then drops enable with engine-busy held high, fires writes, bytes and a slave-read strobe into the disabled block, and only afterwards releases engine-busy. This way the retain phase and the idle-clear phase are each observed separately. A second hard corner is a clamped threshold. It is reached by programming a receive threshold far above the depth and filling the queue one entry at a time up to the last slot.

// File: rtl/fis_pkg.sv
package fis_pkg;
   localparam int unsigned NFLAG   = 7;
   localparam int unsigned NSTICKY = 5;
   localparam int unsigned ST_TX_LOW  = 0;
   localparam int unsigned ST_RX_HIGH = 1;
   localparam int unsigned ST_TX_OVF  = 2;
   localparam int unsigned ST_RX_OVF  = 3;
   localparam int unsigned ST_RX_UNF  = 4;
   localparam int unsigned ST_RD_REQ  = 5;
   localparam int unsigned ST_ABORT   = 6;
   localparam int unsigned STICKY_BASE = ST_TX_OVF;
   localparam int unsigned LAST_IDLE_CLR = ST_RX_UNF;
endpackage

// File: rtl/fis_fifo.sv
module fis_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          full, empty, push_ok, pop_ok;

   initial begin : elab_chk
      assert (DEPTH >= 2) else $error("fis_fifo: DEPTH must be at least 2");
      assert (LW >= $clog2(DEPTH + 1)) else $error("fis_fifo: LW too narrow");
   end

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   p_flush_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));
   p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (level == LW'(DEPTH)));
endmodule

// File: rtl/fis_thresh.sv
module fis_thresh #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned TW    = 8,
   parameter int unsigned LW    = $clog2(DEPTH + 1),
   parameter bit          ABOVE = 1'b1
) (
   input  logic [TW-1:0] thr,
   input  logic [LW-1:0] level,
   output logic          hit
);
   localparam int unsigned CW = ((TW > LW) ? TW : LW) + 1;
   localparam logic [CW-1:0] CAP = CW'(DEPTH - 1);

   logic [CW-1:0] thr_w, lvl_w, eff;

   initial begin : elab_chk
      assert (DEPTH <= (1 << TW)) else $error("fis_thresh: TW too narrow for DEPTH");
   end

   assign thr_w = CW'(thr);
   assign lvl_w = CW'(level);
   assign eff   = (thr_w > CAP) ? CAP : thr_w;

   generate
      if (ABOVE) begin : g_above
         assign hit = (lvl_w > eff);
      end else begin : g_below
         assign hit = (lvl_w <= eff);
      end
   endgenerate
endmodule

// File: rtl/fis_flag.sv
module fis_flag #(
   parameter bit IDLE_CLR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic idle_i,
   output logic flag_o
);
   logic drop;

   generate
      if (IDLE_CLR) begin : g_idle
         assign drop = clr_i || idle_i;
      end else begin : g_strobe
         logic unused_idle;
         assign unused_idle = idle_i;
         assign drop = clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (drop)  flag_o <= 1'b0;
   end

   p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
   import fis_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   parameter int unsigned TW    = 8,
   parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               engine_busy,
   input  logic               cpu_wr,
   input  logic [DW-1:0]      cpu_wdata,
   input  logic               cpu_rd,
   output logic [DW-1:0]      cpu_rdata,
   input  logic               tx_pop,
   output logic [DW-1:0]      tx_dout,
   input  logic               rx_vld,
   input  logic [DW-1:0]      rx_data,
   input  logic               slv_rd_addr,
   input  logic               abort_evt,
   input  logic [TW-1:0]      rx_thr,
   input  logic [TW-1:0]      tx_thr,
   input  logic [NSTICKY-1:0] clr_mask,
   output logic [LW-1:0]      tx_level,
   output logic [LW-1:0]      rx_level,
   output logic [NFLAG-1:0]   raw_status,
   output logic               hold_scl
);
   logic flush, idle, tx_full, rx_full, rx_empty;
   logic tx_low, rx_high;
   logic [NSTICKY-1:0] set_v, flag_v;

   assign flush = !enable;
   assign idle  = !enable && !engine_busy;

   fis_fifo #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(enable && cpu_wr), .wdata(cpu_wdata),
      .pop(enable && tx_pop), .rdata(tx_dout), .level(tx_level));

   fis_fifo #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(enable && rx_vld), .wdata(rx_data),
      .pop(enable && cpu_rd), .rdata(cpu_rdata), .level(rx_level));

   assign tx_full  = (tx_level == LW'(DEPTH));
   assign rx_full  = (rx_level == LW'(DEPTH));
   assign rx_empty = (rx_level == '0);

   fis_thresh #(.DEPTH(DEPTH), .TW(TW), .LW(LW), .ABOVE(1'b0)) u_txthr (
      .thr(tx_thr), .level(tx_level), .hit(tx_low));
   fis_thresh #(.DEPTH(DEPTH), .TW(TW), .LW(LW), .ABOVE(1'b1)) u_rxthr (
      .thr(rx_thr), .level(rx_level), .hit(rx_high));

   assign set_v[ST_TX_OVF - STICKY_BASE] = enable && cpu_wr && tx_full;
   assign set_v[ST_RX_OVF - STICKY_BASE] = enable && rx_vld && rx_full;
   assign set_v[ST_RX_UNF - STICKY_BASE] = enable && cpu_rd && rx_empty;
   assign set_v[ST_RD_REQ - STICKY_BASE] = enable && slv_rd_addr;
   assign set_v[ST_ABORT  - STICKY_BASE] = enable && abort_evt;

   generate
      for (genvar i = 0; i < NSTICKY; i++) begin : g_flag
         fis_flag #(.IDLE_CLR((i + STICKY_BASE) <= LAST_IDLE_CLR)) u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_mask[i]),
            .idle_i(idle), .flag_o(flag_v[i]));
      end
   endgenerate

   assign raw_status[ST_TX_LOW]  = enable ? tx_low : engine_busy;
   assign raw_status[ST_RX_HIGH] = enable && rx_high;
   assign raw_status[NFLAG-1:STICKY_BASE] = flag_v;
   assign hold_scl = flag_v[ST_RD_REQ - STICKY_BASE];

   p_rx_high_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !raw_status[ST_RX_HIGH]);
   p_txovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cpu_wr && tx_level == LW'(DEPTH)) |=> raw_status[ST_TX_OVF]);
   p_rxovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && rx_vld && rx_level == LW'(DEPTH)) |=> raw_status[ST_RX_OVF]);
   p_rxunf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> (cpu_rdata == '0));
   p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !engine_busy) |=> (raw_status[ST_RX_UNF:ST_TX_OVF] == '0));
   p_hold_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && slv_rd_addr) |=> hold_scl);
   p_no_event_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !$past(enable)) |-> (tx_level == '0 && rx_level == '0));
endmodule

// File: tb/fifo_irq_status_tb_top.sv
module fifo_irq_status_tb_top;
   localparam int DEPTH = 16;
   localparam int DW = 8;
   localparam int TW = 8;
   localparam int LW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 1'b0, engine_busy = 1'b0;
   logic cpu_wr = 1'b0, cpu_rd = 1'b0, tx_pop = 1'b0, rx_vld = 1'b0;
   logic slv_rd_addr = 1'b0, abort_evt = 1'b0;
   logic [DW-1:0] cpu_wdata = '0, rx_data = '0;
   logic [TW-1:0] rx_thr = '0, tx_thr = '0;
   logic [4:0] clr_mask = '0;
   logic [DW-1:0] cpu_rdata, tx_dout;
   logic [LW-1:0] tx_level, rx_level;
   logic [6:0] raw_status;
   logic hold_scl;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fifo_irq_status #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .engine_busy(engine_busy),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
      .tx_pop(tx_pop), .tx_dout(tx_dout), .rx_vld(rx_vld), .rx_data(rx_data),
      .slv_rd_addr(slv_rd_addr), .abort_evt(abort_evt), .rx_thr(rx_thr),
      .tx_thr(tx_thr), .clr_mask(clr_mask), .tx_level(tx_level),
      .rx_level(rx_level), .raw_status(raw_status), .hold_scl(hold_scl));

   // behavioural reference model
   byte unsigned txq[$], rxq[$];
   bit m_txo, m_rxo, m_rxu, m_rdq, m_abt;

   always @(posedge clk) begin
      int txs, rxs;
      bit s_txo, s_rxo, s_rxu, s_rdq, s_abt, idl;
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         {m_txo, m_rxo, m_rxu, m_rdq, m_abt} = '0;
      end else begin
         txs = txq.size(); rxs = rxq.size();
         s_txo = enable && cpu_wr && txs == DEPTH;
         s_rxo = enable && rx_vld && rxs == DEPTH;
         s_rxu = enable && cpu_rd && rxs == 0;
         s_rdq = enable && slv_rd_addr;
         s_abt = enable && abort_evt;
         idl = !enable && !engine_busy;
         if (enable) begin
            if (tx_pop && txs > 0) void'(txq.pop_front());
            if (cpu_wr && txs < DEPTH) txq.push_back(cpu_wdata);
            if (cpu_rd && rxs > 0) void'(rxq.pop_front());
            if (rx_vld && rxs < DEPTH) rxq.push_back(rx_data);
         end else begin
            txq.delete(); rxq.delete();
         end
         m_txo = s_txo ? 1'b1 : ((clr_mask[0] || idl) ? 1'b0 : m_txo);
         m_rxo = s_rxo ? 1'b1 : ((clr_mask[1] || idl) ? 1'b0 : m_rxo);
         m_rxu = s_rxu ? 1'b1 : ((clr_mask[2] || idl) ? 1'b0 : m_rxu);
         m_rdq = s_rdq ? 1'b1 : (clr_mask[3] ? 1'b0 : m_rdq);
         m_abt = s_abt ? 1'b1 : (clr_mask[4] ? 1'b0 : m_abt);
      end
   end

   function automatic int eff_thr(int t);
      return (t > DEPTH - 1) ? DEPTH - 1 : t;
   endfunction

   task automatic cmp(int act, int exp, string req, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp(tx_level, txq.size(), "R1", "tx_level");
         cmp(rx_level, rxq.size(), "R1", "rx_level");
         cmp(tx_dout, txq.size() ? txq[0] : 0, "R1", "tx_dout");
         cmp(cpu_rdata, rxq.size() ? rxq[0] : 0, "R8", "cpu_rdata");
         cmp(raw_status[0], enable ? (txq.size() <= eff_thr(tx_thr)) : engine_busy, "R4", "tx_low");
         cmp(raw_status[1], enable && (rxq.size() > eff_thr(rx_thr)), "R2", "rx_high");
         cmp(raw_status[2], m_txo, "R6", "tx_ovf");
         cmp(raw_status[3], m_rxo, "R7", "rx_ovf");
         cmp(raw_status[4], m_rxu, "R8", "rx_unf");
         cmp(raw_status[5], m_rdq, "R10", "rd_req");
         cmp(raw_status[6], m_abt, "R11", "abort");
         cmp(hold_scl, m_rdq, "R10", "hold_scl");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic cyc();
      @(posedge clk); #2;
      {cpu_wr, cpu_rd, tx_pop, rx_vld, slv_rd_addr, abort_evt} = '0;
      clr_mask = '0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      settle();
      cmp(raw_status, 0, "R5", "status after reset");
      cmp(tx_level, 0, "R5", "tx_level after reset");
      enable = 1'b1; tx_thr = 3; rx_thr = 3;
      cyc(); settle();
      cmp(raw_status[0], 1, "R4", "tx_low empty queue");
      // four writes lift tx level above threshold 3
      for (int i = 0; i < 4; i++) begin cpu_wr = 1; cpu_wdata = 8'hA0 + 8'(i); cyc(); end
      settle();
      cmp(tx_level, 4, "R1", "tx_level after 4 writes");
      cmp(raw_status[0], 0, "R4", "tx_low above thr");
      cmp(tx_dout, 8'hA0, "R1", "tx head order");
      for (int i = 0; i < 4; i++) begin tx_pop = 1; cyc(); end
      // overfill transmit queue
      for (int i = 0; i < DEPTH; i++) begin cpu_wr = 1; cpu_wdata = 8'h10 + 8'(i); cyc(); end
      cpu_wr = 1; cpu_wdata = 8'hEE; cyc(); settle();
      cmp(raw_status[2], 1, "R6", "tx overflow flag");
      cmp(tx_level, DEPTH, "R6", "tx level held");
      cmp(tx_dout, 8'h10, "R6", "tx head unchanged");
      for (int i = 0; i < DEPTH; i++) begin tx_pop = 1; tx_thr = 8'(i % 5); cyc(); end
      tx_thr = 3;
      // overfill receive queue
      for (int i = 0; i <= DEPTH; i++) begin rx_vld = 1; rx_data = 8'h40 + 8'(i); cyc(); end
      settle();
      cmp(raw_status[3], 1, "R7", "rx overflow flag");
      cmp(raw_status[1], 1, "R2", "rx high when full");
      for (int i = 0; i < DEPTH; i++) begin cpu_rd = 1; cyc(); end
      settle();
      cmp(raw_status[1], 0, "R2", "rx high clears when drained");
      cpu_rd = 1; cyc(); settle();
      cmp(raw_status[4], 1, "R8", "rx underflow flag");
      cmp(cpu_rdata, 0, "R8", "rdata zero on empty");
      // clear together with a new underflow: set wins
      cpu_rd = 1; clr_mask = 5'b00111; cyc(); settle();
      cmp(raw_status[4], 1, "R12", "set beats clear");
      cmp(raw_status[2], 0, "R12", "tx_ovf cleared");
      cmp(raw_status[3], 0, "R12", "rx_ovf cleared");
      clr_mask = 5'b00100; cyc(); settle();
      cmp(raw_status[4], 0, "R12", "rx_unf cleared");
      // clamped receive threshold
      rx_thr = 200;
      for (int i = 0; i < DEPTH - 1; i++) begin rx_vld = 1; rx_data = 8'(i * 3); cyc(); end
      settle();
      cmp(raw_status[1], 0, "R3", "clamped thr at DEPTH-1 entries");
      rx_vld = 1; rx_data = 8'h99; cyc(); settle();
      cmp(raw_status[1], 1, "R3", "clamped thr at DEPTH entries");
      for (int i = 0; i < DEPTH; i++) begin cpu_rd = 1; cyc(); end
      rx_thr = 0;
      rx_vld = 1; rx_data = 8'h5A; cyc(); settle();
      cmp(raw_status[1], 1, "R2", "thr 0 fires at one entry");
      cpu_rd = 1; cyc();
      // read request and abort
      slv_rd_addr = 1; cyc(); repeat (3) cyc(); settle();
      cmp(hold_scl, 1, "R10", "hold until cleared");
      clr_mask = 5'b01000; cyc(); settle();
      cmp(hold_scl, 0, "R10", "hold released");
      abort_evt = 1; cyc(); cyc(); settle();
      cmp(raw_status[6], 1, "R11", "abort sticky");
      clr_mask = 5'b10000; cyc(); settle();
      cmp(raw_status[6], 0, "R11", "abort cleared");
      // disable while busy with error flags set
      for (int i = 0; i <= DEPTH; i++) begin cpu_wr = 1; cpu_wdata = 8'(i); cyc(); end
      cpu_rd = 1; cyc();
      engine_busy = 1; enable = 0; cyc(); settle();
      cmp(tx_level, 0, "R5", "tx flushed");
      cmp(raw_status[0], 1, "R5", "tx_low follows busy");
      cmp(raw_status[2], 1, "R9", "tx_ovf retained while busy");
      cmp(raw_status[4], 1, "R9", "rx_unf retained while busy");
      cpu_wr = 1; rx_vld = 1; slv_rd_addr = 1; abort_evt = 1; cpu_rd = 1; cyc(); settle();
      cmp(rx_level, 0, "R13", "rx ignored while off");
      cmp(tx_level, 0, "R13", "tx ignored while off");
      cmp(raw_status[5], 0, "R13", "slave read ignored while off");
      cmp(raw_status[6], 0, "R13", "abort ignored while off");
      engine_busy = 0; cyc(); settle();
      cmp(raw_status[2], 0, "R9", "tx_ovf idle clear");
      cmp(raw_status[4], 0, "R9", "rx_unf idle clear");
      cmp(raw_status[0], 0, "R5", "tx_low off idle");
      enable = 1; repeat (3) cyc(); settle();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule